// File: doc/BRIEF.md
# Supply-Fail Reset and Nonvolatile Save/Restore Sequencer

This block is the digital half of a supply supervisor. A synchronised comparator flag reports whether the supply is above its trip level; the comparator already has hysteresis, so the block takes the flag as it comes. From that flag the block drives the system reset, gates serial and parallel memory access, and issues a one-cycle abort to the serial command engine when the supply drops.

On a supply failure it orders two nonvolatile operations. Any serial nonvolatile write that is already under way is allowed to finish first. Only then does the save of the volatile nibble into its shadow cells run, for a fixed number of clock cycles. When the supply comes back, reset stays asserted for a power-up timeout. A new drop during that timeout starts the timeout over. After the timeout the block releases reset and runs the restore. Only when the restore has ended does it report the output ports valid and lift the access gate. Every duration is a parameter counted in system clocks.

Top module: `sup_lvr_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `reset_out` and `access_block` are 1, and `cmd_abort`, `store_active`, `recall_active` and `ports_valid` are 0.
- R2: A fall of `vcc_above_trip` during normal operation raises `reset_out` and `access_block` and pulses `cmd_abort` for one cycle, SYNC_STAGES clock edges after the fall. `ports_valid` drops in the same cycle.
- R3: If `nv_write_busy` is 0 when the fall is seen, `store_active` rises at the next edge and stays high for exactly STORE_CYC cycles.
- R4: If `nv_write_busy` is 1 when the fall is seen, `store_active` stays 0 until `nv_write_busy` is sampled 0. It then rises at that edge.
- R5: After the save, `reset_out` and `access_block` stay 1, with no save and no restore active, for as long as the supply flag stays low.
- R6: After the synchronised supply flag rises, `reset_out` stays 1 for one cycle plus PURST_CYC cycles, and then falls.
- R7: A drop of the supply flag before the power-up timeout ends discards the partial count. The next rise needs the full timeout again.
- R8: `recall_active` is high for RECALL_CYC cycles, starting in the cycle in which `reset_out` falls. `access_block` stays 1 through the restore. `ports_valid` rises and `access_block` falls in the cycle after the restore ends.
- R9: A supply drop during the restore reasserts `reset_out` and abandons the restore without starting a save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| vcc_above_trip | input | 1 | Comparator flag; 1 means the supply is above the trip level |
| nv_write_busy | input | 1 | 1 while a serial nonvolatile write cycle is in progress |
| reset_out | output | 1 | System reset, active high |
| access_block | output | 1 | 1 blocks new serial and parallel memory operations |
| cmd_abort | output | 1 | One-cycle pulse that aborts the current serial command |
| store_active | output | 1 | Save of the volatile nibble into the shadow cells is running |
| recall_active | output | 1 | Restore of the volatile nibble from the shadow cells is running |
| ports_valid | output | 1 | Output port values are valid |

## Verification
The bench builds the block with SYNC_STAGES=2, STORE_CYC=6, PURST_CYC=20 and RECALL_CYC=5. These short windows let every phase boundary be sampled on the exact edge where it falls: the last save cycle, the last timeout cycle and the last restore cycle. They also allow several full power cycles within a short run. With these values a timeout can be interrupted partway and then rerun in full. A write-busy hold can be stretched well past the save length, and a drop can land inside the five-cycle restore.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    PH_RUN  = 3'd0,  // supply good, ports valid
    PH_HOLD = 3'd1,  // supply lost, serial nonvolatile write still finishing
    PH_SAVE = 3'd2,  // volatile nibble being saved
    PH_DOWN = 3'd3,  // saved, waiting for supply
    PH_TMO  = 3'd4,  // power-up timeout
    PH_LOAD = 3'd5   // restore from shadow cells
  } sup_phase_t;

  // Length in cycles of a counted phase; 0 for phases without a count.
  function automatic int unsigned phase_len(input sup_phase_t ph,
                                            input int unsigned save_len,
                                            input int unsigned tmo_len,
                                            input int unsigned load_len);
    case (ph)
      PH_SAVE: return save_len;
      PH_TMO:  return tmo_len;
      PH_LOAD: return load_len;
      default: return 0;
    endcase
  endfunction

  // True in the final cycle of a phase of length len.
  function automatic logic span_end(input logic [31:0] cnt, input int unsigned len);
    return (len == 0) || (cnt == (32'(len) - 32'd1));
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_timer.sv
module sup_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (run) count <= count + 1'b1;
  end
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
#(
  parameter int W          = 8,
  parameter int STORE_CYC  = 6,
  parameter int PURST_CYC  = 20,
  parameter int RECALL_CYC = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         nvw_busy,
  input  logic [W-1:0] count,
  output sup_phase_t   phase,
  output logic         tmr_clr,
  output logic         tmr_run,
  output logic         phase_done
);
  sup_phase_t nxt;

  assign phase_done = span_end(32'(count),
                               phase_len(phase, STORE_CYC, PURST_CYC, RECALL_CYC));

  always_comb begin
    nxt = phase;
    case (phase)
      PH_RUN:  if (!supply_ok) nxt = nvw_busy ? PH_HOLD : PH_SAVE;
      PH_HOLD: if (!nvw_busy)  nxt = PH_SAVE;
      PH_SAVE: if (phase_done) nxt = PH_DOWN;
      PH_DOWN: if (supply_ok)  nxt = PH_TMO;
      PH_TMO: begin
        if (!supply_ok)      nxt = PH_DOWN;
        else if (phase_done) nxt = PH_LOAD;
      end
      PH_LOAD: begin
        if (!supply_ok)      nxt = PH_DOWN;
        else if (phase_done) nxt = PH_RUN;
      end
      default: nxt = PH_DOWN;
    endcase
  end

  assign tmr_clr = (nxt != phase);
  assign tmr_run = (phase == PH_SAVE) || (phase == PH_TMO) || (phase == PH_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_DOWN;
    else        phase <= nxt;
  end
endmodule

// File: rtl/sup_lvr_seq.sv
module sup_lvr_seq
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STORE_CYC   = 1_250_000,
  parameter int PURST_CYC   = 50_000_000,
  parameter int RECALL_CYC  = 2_500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_above_trip,
  input  logic nv_write_busy,
  output logic reset_out,
  output logic access_block,
  output logic cmd_abort,
  output logic store_active,
  output logic recall_active,
  output logic ports_valid
);
  localparam int MAX_A   = (STORE_CYC > PURST_CYC) ? STORE_CYC : PURST_CYC;
  localparam int MAX_LEN = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
  localparam int CW      = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  logic          supply_ok;
  logic          tmr_clr;
  logic          tmr_run;
  logic          phase_done;
  logic [CW-1:0] count;
  sup_phase_t    phase;

  sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(vcc_above_trip), .q(supply_ok)
  );

  sup_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .count(count)
  );

  sup_fsm #(
    .W(CW), .STORE_CYC(STORE_CYC), .PURST_CYC(PURST_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .nvw_busy(nv_write_busy),
    .count(count), .phase(phase), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .phase_done(phase_done)
  );

  logic in_up;
  assign in_up         = (phase == PH_RUN) || (phase == PH_LOAD);
  assign reset_out     = !in_up || !supply_ok;
  assign access_block  = (phase != PH_RUN) || !supply_ok;
  assign cmd_abort     = (phase == PH_RUN) && !supply_ok;
  assign store_active  = (phase == PH_SAVE);
  assign recall_active = (phase == PH_LOAD);
  assign ports_valid   = (phase == PH_RUN) && supply_ok;
endmodule

// File: rtl/sup_lvr_seq_chk.sv
module sup_lvr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic nv_write_busy,
  input logic supply_ok,
  input logic phase_done,
  input logic reset_out,
  input logic cmd_abort,
  input logic store_active,
  input logic recall_active,
  input logic ports_valid
);
  assert_abort_then_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> reset_out && !ports_valid && !cmd_abort);

  assert_save_runs_to_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_active && !phase_done |=> store_active);

  assert_save_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_active) |-> !$past(nv_write_busy));

  assert_phases_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_active, recall_active, ports_valid}));

  assert_release_after_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_out) |-> $past(phase_done) && recall_active);

  assert_valid_after_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ports_valid) |-> $past(recall_active));

  assert_no_save_from_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recall_active && !supply_ok |=> !store_active && !recall_active);
endmodule

bind sup_lvr_seq sup_lvr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nv_write_busy(nv_write_busy),
  .supply_ok(supply_ok), .phase_done(phase_done), .reset_out(reset_out),
  .cmd_abort(cmd_abort), .store_active(store_active),
  .recall_active(recall_active), .ports_valid(ports_valid)
);

// File: tb/sup_lvr_seq_test.sv
module sup_lvr_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vok = 1'b0;
  logic busy = 1'b0;
  logic rst_o, blk, abt, sto, rcl, pv;
  int   n_vec = 0;
  int   n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sup_lvr_seq #(
    .SYNC_STAGES(2), .STORE_CYC(6), .PURST_CYC(20), .RECALL_CYC(5)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vcc_above_trip(vok), .nv_write_busy(busy),
    .reset_out(rst_o), .access_block(blk), .cmd_abort(abt),
    .store_active(sto), .recall_active(rcl), .ports_valid(pv)
  );

  typedef struct packed {
    logic       vok;
    logic       busy;
    logic [7:0] n;
    logic [5:0] exp;   // {reset, block, abort, store, recall, valid}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd22, 6'b110000, 4'd6},  // R6 timeout still running
    '{1'b1, 1'b0, 8'd1,  6'b010010, 4'd6},  // R6 released
    '{1'b1, 1'b0, 8'd4,  6'b010010, 4'd8},  // R8 restore last cycle
    '{1'b1, 1'b0, 8'd1,  6'b000001, 4'd8},  // R8 valid
    '{1'b0, 1'b0, 8'd1,  6'b000001, 4'd2},  // R2 one sync stage in
    '{1'b0, 1'b0, 8'd1,  6'b111000, 4'd2},  // R2 abort pulse
    '{1'b0, 1'b0, 8'd1,  6'b110100, 4'd3},  // R3 save begins
    '{1'b0, 1'b0, 8'd5,  6'b110100, 4'd3},  // R3 last save cycle
    '{1'b0, 1'b0, 8'd1,  6'b110000, 4'd5},  // R5 saved
    '{1'b0, 1'b0, 8'd10, 6'b110000, 4'd5},  // R5 stays down
    '{1'b1, 1'b0, 8'd22, 6'b110000, 4'd6},  // R6
    '{1'b1, 1'b0, 8'd1,  6'b010010, 4'd6},  // R6
    '{1'b1, 1'b0, 8'd4,  6'b010010, 4'd8},  // R8
    '{1'b1, 1'b0, 8'd1,  6'b000001, 4'd8},  // R8
    '{1'b0, 1'b1, 8'd2,  6'b111000, 4'd2},  // R2 with write busy
    '{1'b0, 1'b1, 8'd1,  6'b110000, 4'd4},  // R4 held for write
    '{1'b0, 1'b1, 8'd10, 6'b110000, 4'd4},  // R4 still held
    '{1'b0, 1'b0, 8'd1,  6'b110100, 4'd4},  // R4 save after write
    '{1'b0, 1'b0, 8'd5,  6'b110100, 4'd3},  // R3
    '{1'b0, 1'b0, 8'd1,  6'b110000, 4'd5},  // R5
    '{1'b1, 1'b0, 8'd12, 6'b110000, 4'd7},  // R7 timeout partway
    '{1'b0, 1'b0, 8'd3,  6'b110000, 4'd7},  // R7 drop
    '{1'b1, 1'b0, 8'd22, 6'b110000, 4'd7},  // R7 full timeout again
    '{1'b1, 1'b0, 8'd1,  6'b010010, 4'd7},  // R7 released
    '{1'b1, 1'b0, 8'd1,  6'b010010, 4'd8},  // R8
    '{1'b0, 1'b0, 8'd2,  6'b110010, 4'd9},  // R9 drop seen in restore
    '{1'b0, 1'b0, 8'd1,  6'b110000, 4'd9},  // R9 no save
    '{1'b0, 1'b0, 8'd8,  6'b110000, 4'd9}   // R9 still no save
  };

  task automatic check(input logic [5:0] exp, input int req, input int idx);
    logic [5:0] act;
    act = {rst_o, blk, abt, sto, rcl, pv};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d step %0d: {rst,blk,abt,sto,rcl,pv} actual %b expected %b",
               req, idx, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(6'b110000, 1, -1);              // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(6'b110000, 1, -2);              // R1 after release
    for (int i = 0; i < NV; i++) begin
      vok  = VECS[i].vok;
      busy = VECS[i].busy;
      repeat (int'(VECS[i].n)) @(negedge clk);
      check(VECS[i].exp, int'(VECS[i].req), i);
    end
    // Directed: bring the block up, then reset it mid-run (R1)
    vok = 1'b1;
    repeat (28) @(negedge clk);
    check(6'b000001, 8, 100);             // R8 up again
    rst_n = 1'b0;
    @(negedge clk);
    check(6'b110000, 1, 101);             // R1 reset mid-run
    rst_n = 1'b1;
    @(negedge clk);
    check(6'b110000, 1, 102);             // R1
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(negedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule